// File: doc/BRIEF.md
# ALU Condition and Shift-Control Status Register

This block keeps the condition state left by the integer ALU together with two small operand-steering fields. The flags are divide, overflow, negative, zero and carry. The steering fields are a 2-bit byte pointer, used by byte insert and extract, and a 5-bit funnel-shift count, used by extract. After every ALU operation the pipeline presents the result, the carry-out and the carry into the most significant bit, plus a bit that says whether the operation was arithmetic or logical. The register updates the matching flags on the next clock edge. The stored carry is driven back out so that add-with-carry and subtract-with-carry can use it.

Software reaches the register through move-to-special-register writes. A write can target the whole word or one of two narrow alias views. One view holds only the byte pointer and the other holds only the shift count. Each view reads its field right-justified with zeros above, and writing a view leaves every other field alone. A load or store whose set-pointer bit is on also writes the byte pointer. It takes either the two low address bits or a value derived from the byte-order configuration bit, as the word-mode configuration bit selects.

All updates take effect at the rising clock edge after the request. All outputs come straight from the stored state.

Top module: `aluStatusReg`

## Requirements
- R1: After reset the full word, both alias views and the carry output are all zero.
- R2: A write with select code 0 loads bits 11:0 from the write data: bit 11 divide, 10 V, 9 N, 8 Z, 7 C, 6:5 byte pointer and 4:0 shift count. Bits 31:12 always read as zero. Select code 3 addresses no field of this block and changes nothing.
- R3: An arithmetic update sets C to the carry-out and V to the carry-out XOR the carry into the MSB.
- R4: Every ALU update, arithmetic or logical, sets N to result bit DATA_W-1 and sets Z when the whole result is zero.
- R5: A logical update leaves V and C unchanged.
- R6: The byte-pointer view (select code 1) reads the pointer in bits 1:0 with zeros above. A write to it loads only the pointer from data bits 1:0.
- R7: The shift-count view (select code 2) reads the count in bits 4:0 with zeros above. A write to it loads only the count from data bits 4:0.
- R8: A load or store with the set-pointer bit on and the word-mode bit at 0 loads the pointer from the two address LSBs. With the set-pointer bit off, the pointer is untouched.
- R9: With the word-mode bit at 1, such a load or store loads the pointer with bit 1 equal to the inverted byte-order bit and bit 0 equal to zero.
- R10: An explicit register write in the same cycle as a flag update or a load/store pointer update wins for every field it writes.
- R11: The carry output always equals the stored C bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aluValid | input | 1 | An ALU result is presented this cycle |
| aluIsArith | input | 1 | 1 for arithmetic, 0 for logical |
| aluResult | input | DATA_W | ALU result |
| aluCarryOut | input | 1 | ALU carry-out |
| aluCarryMsb | input | 1 | Carry into the result MSB |
| mtsrValid | input | 1 | Register write request |
| mtsrSel | input | 2 | Write target: 0 full, 1 pointer view, 2 count view, 3 none |
| mtsrData | input | 32 | Write data |
| lsValid | input | 1 | Load or store issued this cycle |
| lsSetBp | input | 1 | Load/store asks to set the byte pointer |
| lsAddrLsb | input | 2 | Two low address bits of the access |
| cfgDw | input | 1 | Word-mode configuration bit |
| cfgByteOrder | input | 1 | Byte-order configuration bit |
| statusWord | output | 32 | Full register read |
| bpAlias | output | 32 | Byte-pointer view read |
| fcAlias | output | 32 | Shift-count view read |
| carryIn | output | 1 | Stored carry for carry-chained operations |

## Verification
Directed vectors separate the two kinds of ALU update. A result with the MSB set and unequal carries must raise V and N. A later logical zero result must raise Z and leave V and C where they were. Pointer-source vectors try both word-mode settings with both byte-order values and with the set-pointer bit off, which tells the address path apart from the configuration path. Collision vectors put a full write, an alias write, a flag update and a load/store pointer update in one cycle, so they expose any wrong priority. Random vectors mix all sources at once and are compared field by field against a bench-side model.

// File: rtl/aluStatusPkg.sv
package aluStatusPkg;
  localparam int REG_W  = 32;
  localparam int FC_W   = 5;
  localparam int BP_W   = 2;
  localparam int FC_LSB = 0;
  localparam int BP_LSB = FC_LSB + FC_W;
  localparam int C_POS  = BP_LSB + BP_W;
  localparam int Z_POS  = C_POS + 1;
  localparam int N_POS  = Z_POS + 1;
  localparam int V_POS  = N_POS + 1;
  localparam int DF_POS = V_POS + 1;
  localparam int USED_W = DF_POS + 1;

  typedef enum logic [1:0] {
    SEL_FULL = 2'd0,
    SEL_BP   = 2'd1,
    SEL_FC   = 2'd2,
    SEL_NONE = 2'd3
  } wrSelE;

  typedef struct packed {
    logic wrFull;
    logic wrBp;
    logic wrFc;
    logic updNZ;
    logic updVC;
    logic ldBpLs;
  } strobeT;
endpackage

// File: rtl/aluStatusCtrl.sv
module aluStatusCtrl
  import aluStatusPkg::*;
(
  input  logic            mtsrValid,
  input  logic [1:0]      mtsrSel,
  input  logic            aluValid,
  input  logic            aluIsArith,
  input  logic            lsValid,
  input  logic            lsSetBp,
  input  logic [BP_W-1:0] lsAddrLsb,
  input  logic            cfgDw,
  input  logic            cfgByteOrder,
  output strobeT          strobes,
  output logic [BP_W-1:0] lsBpVal
);
  wrSelE selE;
  assign selE = wrSelE'(mtsrSel);

  always_comb begin
    strobes.wrFull = mtsrValid && (selE == SEL_FULL);
    strobes.wrBp   = mtsrValid && (selE == SEL_BP);
    strobes.wrFc   = mtsrValid && (selE == SEL_FC);
    // a full write owns every field, so it masks all other sources
    strobes.updNZ  = aluValid && !strobes.wrFull;
    strobes.updVC  = aluValid && aluIsArith && !strobes.wrFull;
    strobes.ldBpLs = lsValid && lsSetBp && !strobes.wrFull && !strobes.wrBp;
  end

  // word mode: the pointer MSB picks the half-word from byte order
  always_comb begin
    if (cfgDw) lsBpVal = {~cfgByteOrder, {(BP_W-1){1'b0}}};
    else       lsBpVal = lsAddrLsb;
  end
endmodule

// File: rtl/aluStatusDp.sv
module aluStatusDp
  import aluStatusPkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [USED_W-1:0] wrData,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarryOut,
  input  logic              aluCarryMsb,
  input  logic [BP_W-1:0]   lsBpVal,
  output logic [REG_W-1:0]  statusWord,
  output logic [REG_W-1:0]  bpAlias,
  output logic [REG_W-1:0]  fcAlias,
  output logic              carryIn
);
  logic            divQ, ovfQ, negQ, zeroQ, carryQ;
  logic [BP_W-1:0] bpQ;
  logic [FC_W-1:0] fcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ   <= 1'b0;
      ovfQ   <= 1'b0;
      negQ   <= 1'b0;
      zeroQ  <= 1'b0;
      carryQ <= 1'b0;
      bpQ    <= '0;
      fcQ    <= '0;
    end else if (strobes.wrFull) begin
      divQ   <= wrData[DF_POS];
      ovfQ   <= wrData[V_POS];
      negQ   <= wrData[N_POS];
      zeroQ  <= wrData[Z_POS];
      carryQ <= wrData[C_POS];
      bpQ    <= wrData[BP_LSB +: BP_W];
      fcQ    <= wrData[FC_LSB +: FC_W];
    end else begin
      if (strobes.updNZ) begin
        negQ  <= aluResult[DATA_W-1];
        zeroQ <= ~|aluResult;
      end
      if (strobes.updVC) begin
        carryQ <= aluCarryOut;
        ovfQ   <= aluCarryOut ^ aluCarryMsb;
      end
      if (strobes.wrBp)        bpQ <= wrData[BP_W-1:0];
      else if (strobes.ldBpLs) bpQ <= lsBpVal;
      if (strobes.wrFc)        fcQ <= wrData[FC_W-1:0];
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[DF_POS] = divQ;
    statusWord[V_POS]  = ovfQ;
    statusWord[N_POS]  = negQ;
    statusWord[Z_POS]  = zeroQ;
    statusWord[C_POS]  = carryQ;
    statusWord[BP_LSB +: BP_W] = bpQ;
    statusWord[FC_LSB +: FC_W] = fcQ;
    bpAlias = '0;
    bpAlias[BP_W-1:0] = bpQ;
    fcAlias = '0;
    fcAlias[FC_W-1:0] = fcQ;
  end

  assign carryIn = carryQ;

  AST_ARITH_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updVC |=> carryIn == $past(aluCarryOut)); // R3
  AST_ARITH_OVF: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updVC |=> statusWord[V_POS] == $past(aluCarryOut ^ aluCarryMsb)); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updNZ |=> statusWord[Z_POS] == ($past(aluResult) == '0)); // R4
  AST_LOGIC_KEEPS_VC: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.updNZ && !strobes.updVC) |=> $stable(statusWord[V_POS]) && $stable(carryIn)); // R5
endmodule

// File: rtl/aluStatusReg.sv
module aluStatusReg
  import aluStatusPkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              aluValid,
  input  logic              aluIsArith,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarryOut,
  input  logic              aluCarryMsb,
  input  logic              mtsrValid,
  input  logic [1:0]        mtsrSel,
  input  logic [31:0]       mtsrData,
  input  logic              lsValid,
  input  logic              lsSetBp,
  input  logic [1:0]        lsAddrLsb,
  input  logic              cfgDw,
  input  logic              cfgByteOrder,
  output logic [31:0]       statusWord,
  output logic [31:0]       bpAlias,
  output logic [31:0]       fcAlias,
  output logic              carryIn
);
  strobeT          strobes;
  logic [BP_W-1:0] lsBpVal;
  logic            unusedRsvd;

  assign unusedRsvd = ^mtsrData[REG_W-1:USED_W];

  aluStatusCtrl uCtrl (
    .mtsrValid    (mtsrValid),
    .mtsrSel      (mtsrSel),
    .aluValid     (aluValid),
    .aluIsArith   (aluIsArith),
    .lsValid      (lsValid),
    .lsSetBp      (lsSetBp),
    .lsAddrLsb    (lsAddrLsb),
    .cfgDw        (cfgDw),
    .cfgByteOrder (cfgByteOrder),
    .strobes      (strobes),
    .lsBpVal      (lsBpVal)
  );

  aluStatusDp #(.DATA_W(DATA_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (mtsrData[USED_W-1:0]),
    .aluResult   (aluResult),
    .aluCarryOut (aluCarryOut),
    .aluCarryMsb (aluCarryMsb),
    .lsBpVal     (lsBpVal),
    .statusWord  (statusWord),
    .bpAlias     (bpAlias),
    .fcAlias     (fcAlias),
    .carryIn     (carryIn)
  );

  AST_FULL_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (mtsrValid && mtsrSel == 2'd0) |=>
      statusWord[USED_W-1:0] == $past(mtsrData[USED_W-1:0])); // R10
  AST_BP_VIEW_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    (mtsrValid && mtsrSel == 2'd1 && !aluValid) |=>
      $stable(statusWord[USED_W-1:C_POS]) && $stable(fcAlias)
      && bpAlias[1:0] == $past(mtsrData[1:0])); // R6
  AST_FC_VIEW_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    (mtsrValid && mtsrSel == 2'd2 && !aluValid && !lsValid) |=>
      $stable(statusWord[USED_W-1:BP_LSB]) && fcAlias[4:0] == $past(mtsrData[4:0])); // R7
  AST_LS_ADDR_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (lsValid && lsSetBp && !cfgDw && !mtsrValid) |=>
      bpAlias[1:0] == $past(lsAddrLsb)); // R8
  AST_LS_ORDER_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (lsValid && lsSetBp && cfgDw && !mtsrValid) |=>
      bpAlias[1:0] == {~$past(cfgByteOrder), 1'b0}); // R9
endmodule

// File: tb/tb_aluStatusReg.sv
module tb_aluStatusReg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aluValid = 0, aluIsArith = 0, aluCarryOut = 0, aluCarryMsb = 0;
  logic [31:0] aluResult = '0;
  logic        mtsrValid = 0;
  logic [1:0]  mtsrSel = '0;
  logic [31:0] mtsrData = '0;
  logic        lsValid = 0, lsSetBp = 0, cfgDw = 0, cfgByteOrder = 0;
  logic [1:0]  lsAddrLsb = '0;
  logic [31:0] statusWord, bpAlias, fcAlias;
  logic        carryIn;

  int nChecks = 0;
  int nFail = 0;
  logic [11:0] refQ = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aluStatusReg dut (
    .clk(clk), .rstN(rstN), .aluValid(aluValid), .aluIsArith(aluIsArith),
    .aluResult(aluResult), .aluCarryOut(aluCarryOut), .aluCarryMsb(aluCarryMsb),
    .mtsrValid(mtsrValid), .mtsrSel(mtsrSel), .mtsrData(mtsrData),
    .lsValid(lsValid), .lsSetBp(lsSetBp), .lsAddrLsb(lsAddrLsb),
    .cfgDw(cfgDw), .cfgByteOrder(cfgByteOrder),
    .statusWord(statusWord), .bpAlias(bpAlias), .fcAlias(fcAlias), .carryIn(carryIn)
  );

  // model: [11] div, [10] V, [9] N, [8] Z, [7] C, [6:5] ptr, [4:0] count
  function automatic logic [11:0] nextRef(logic [11:0] cur);
    logic [11:0] nx = cur;
    if (aluValid) begin
      nx[9] = aluResult[31];
      nx[8] = (aluResult == 32'd0);
      if (aluIsArith) begin
        nx[7]  = aluCarryOut;
        nx[10] = aluCarryOut ^ aluCarryMsb;
      end
    end
    if (lsValid && lsSetBp) nx[6:5] = cfgDw ? {~cfgByteOrder, 1'b0} : lsAddrLsb;
    if (mtsrValid) begin
      case (mtsrSel)
        2'd0: nx = mtsrData[11:0];
        2'd1: nx[6:5] = mtsrData[1:0];
        2'd2: nx[4:0] = mtsrData[4:0];
        default: ;
      endcase
    end
    return nx;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    check("R2 reserved", {20'd0, statusWord[31:12]}, 32'd0);
    check("R2 div flag", {31'd0, statusWord[11]}, {31'd0, refQ[11]});
    check("R3 V/C", {30'd0, statusWord[10], statusWord[7]}, {30'd0, refQ[10], refQ[7]});
    check("R4 N/Z", {30'd0, statusWord[9:8]}, {30'd0, refQ[9:8]});
    check("R8 ptr field", {30'd0, statusWord[6:5]}, {30'd0, refQ[6:5]});
    check("R7 count field", {27'd0, statusWord[4:0]}, {27'd0, refQ[4:0]});
    check("R6 ptr view", bpAlias, {30'd0, refQ[6:5]});
    check("R7 count view", fcAlias, {27'd0, refQ[4:0]});
    check("R11 carry out", {31'd0, carryIn}, {31'd0, refQ[7]});
  endtask

  task automatic idle();
    aluValid = 0; mtsrValid = 0; lsValid = 0; lsSetBp = 0;
  endtask

  task automatic tick();
    refQ = nextRef(refQ);
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1A5C_0DE5));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 full word", statusWord, 32'd0);
    check("R1 ptr view", bpAlias, 32'd0);
    check("R1 count view", fcAlias, 32'd0);
    check("R1 carry", {31'd0, carryIn}, 32'd0);

    // R2: full write, reserved bits read zero
    mtsrValid = 1; mtsrSel = 2'd0; mtsrData = 32'hFFFF_FFFF; tick();
    check("R2 full write", statusWord, 32'h0000_0FFF);
    mtsrValid = 1; mtsrSel = 2'd3; mtsrData = 32'd0; tick();
    check("R2 select 3 ignored", statusWord, 32'h0000_0FFF);

    // R3 R4: arithmetic update
    aluValid = 1; aluIsArith = 1; aluResult = 32'h8000_0000;
    aluCarryOut = 0; aluCarryMsb = 1; tick();
    check("R3 arith V=1 C=0", {30'd0, statusWord[10], statusWord[7]}, 32'd2);
    check("R4 arith N=1 Z=0", {30'd0, statusWord[9:8]}, 32'd2);

    // R5: logical zero result keeps V and C
    aluValid = 1; aluIsArith = 0; aluResult = 32'd0;
    aluCarryOut = 1; aluCarryMsb = 0; tick();
    check("R5 logical V/C kept", {30'd0, statusWord[10], statusWord[7]}, 32'd2);
    check("R4 logical N=0 Z=1", {30'd0, statusWord[9:8]}, 32'd1);

    // R6: pointer view write
    mtsrValid = 1; mtsrSel = 2'd1; mtsrData = 32'hFFFF_FFFE; tick();
    check("R6 ptr view write", bpAlias, 32'd2);
    check("R6 other fields kept", {20'd0, statusWord[11:7], 2'b00, statusWord[4:0]},
          {20'd0, refQ[11:7], 2'b00, refQ[4:0]});

    // R7: count view write
    mtsrValid = 1; mtsrSel = 2'd2; mtsrData = 32'hFFFF_FFF3; tick();
    check("R7 count view write", fcAlias, 32'd19);
    check("R7 ptr kept", bpAlias, 32'd2);

    // R8: address source, and set-pointer off
    lsValid = 1; lsSetBp = 0; cfgDw = 0; lsAddrLsb = 2'd1; tick();
    check("R8 set-ptr off", bpAlias, 32'd2);
    lsValid = 1; lsSetBp = 1; cfgDw = 0; lsAddrLsb = 2'd1; tick();
    check("R8 address LSBs", bpAlias, 32'd1);

    // R9: byte-order source
    lsValid = 1; lsSetBp = 1; cfgDw = 1; cfgByteOrder = 0; lsAddrLsb = 2'd3; tick();
    check("R9 order=0", bpAlias, 32'd2);
    lsValid = 1; lsSetBp = 1; cfgDw = 1; cfgByteOrder = 1; tick();
    check("R9 order=1", bpAlias, 32'd0);

    // R10: collisions
    mtsrValid = 1; mtsrSel = 2'd0; mtsrData = 32'h0000_0000;
    aluValid = 1; aluIsArith = 1; aluResult = 32'h8000_0001; aluCarryOut = 1;
    lsValid = 1; lsSetBp = 1; cfgDw = 0; lsAddrLsb = 2'd3; tick();
    check("R10 full write wins", statusWord, 32'd0);
    mtsrValid = 1; mtsrSel = 2'd1; mtsrData = 32'd1;
    lsValid = 1; lsSetBp = 1; cfgDw = 0; lsAddrLsb = 2'd2; tick();
    check("R10 ptr view beats load", bpAlias, 32'd1);
    checkAll();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      aluValid     = ($urandom_range(0, 1) == 1);
      aluIsArith   = $urandom_range(0, 1);
      aluResult    = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom;
      aluCarryOut  = $urandom_range(0, 1);
      aluCarryMsb  = $urandom_range(0, 1);
      mtsrValid    = ($urandom_range(0, 3) == 0);
      mtsrSel      = 2'($urandom_range(0, 3));
      mtsrData     = $urandom;
      lsValid      = ($urandom_range(0, 2) == 0);
      lsSetBp      = $urandom_range(0, 1);
      lsAddrLsb    = 2'($urandom_range(0, 3));
      cfgDw        = $urandom_range(0, 1);
      cfgByteOrder = $urandom_range(0, 1);
      tick();
      checkAll();
    end

    summary();
    $finish;
  end
endmodule